// File: doc/BRIEF.md
# Timestamp Counter with Read and Pulse-Per-Second Snapshots

This block keeps the fast, low-order part of a time-of-day value in hardware. A free-running binary counter advances once for every enabled prescaler tick. When it rolls over it raises an overflow interrupt request. That request stays raised until the host acknowledges it, and the host then advances the high-order part of the time in its own storage. If a second rollover arrives before the host has acknowledged the first, a lost-overflow status bit records it.

Two events can freeze the counter. A host read strobe copies the counter into a read holding register, and the host adds that value, shifted to the correct position, to its upper part. An external pulse-per-second input goes through a synchronizer chain and a rising-edge detector, then copies the counter into a separate capture register. This takes interrupt latency out of the measurement. Each holding register has a sticky valid flag, which for the pulse register is also its interrupt request, and an overrun flag. When a pulse edge and a read strobe land in the same cycle, the pulse capture goes first and the read is taken one cycle later.

Top module: `ts_latch_core`

## Requirements
- R1: Reset sets the counter to zero. The counter adds one on every cycle with `tick_i` high, keeps its value otherwise, and rolls from its all-ones value to zero.
- R2: The cycle after a rollover, `ovf_irq_o` is high. It stays high until acknowledged. An `ack_i` that arrives in the same cycle as a rollover leaves it high.
- R3: An `ack_i` in a cycle with no rollover clears both `ovf_irq_o` and `ovf_lost_o` on the next cycle.
- R4: A rollover while `ovf_irq_o` is high and `ack_i` is low sets `ovf_lost_o` on the next cycle.
- R5: A `rd_strobe_i` with no coincident pulse edge makes `rd_value_o` equal, on the next cycle, to the counter value of the strobe cycle. It also sets `rd_valid_o`.
- R6: Suppose `pps_i` (active high by default) is first seen high at clock edge k. Then at edge k+2 `pps_value_o` takes the counter value held just before that edge, and `pps_valid_o` rises. A level held high captures only once.
- R7: If the pulse edge and `rd_strobe_i` fall in the same cycle, the pulse capture happens on that cycle. The read capture happens one cycle later and holds the counter value of that later cycle.
- R8: A valid flag stays set until its take input (`rd_take_i` or `pps_take_i`) is high. A take with no new capture clears both the valid and overrun flags on the next cycle.
- R9: A capture while the valid flag is set and no take is present sets the overrun flag and overwrites the value with the newer count.
- R10: After reset, every flag output and both holding registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick enable |
| ack_i | input | 1 | Host acknowledge of overflow interrupt |
| rd_strobe_i | input | 1 | Host read snapshot request |
| rd_take_i | input | 1 | Host has consumed the read register |
| pps_i | input | 1 | Asynchronous pulse-per-second input |
| pps_take_i | input | 1 | Host has consumed the pulse capture |
| count_o | output | CNT_W | Live counter value |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| ovf_lost_o | output | 1 | Rollover seen while request pending |
| rd_value_o | output | CNT_W | Read snapshot |
| rd_valid_o | output | 1 | Read snapshot valid |
| rd_overrun_o | output | 1 | Read snapshot overwritten unread |
| pps_value_o | output | CNT_W | Pulse capture snapshot |
| pps_valid_o | output | 1 | Pulse capture valid / interrupt request |
| pps_overrun_o | output | 1 | Pulse capture overwritten unread |

## Verification
The bench builds the block with a 4-bit counter and the default two-stage synchronizer. At that width a rollover comes every sixteen ticks, so a short tick table walks through two rollovers. The second one lands while the interrupt is still pending, which exercises lost-overflow reporting and acknowledge priority without long runs. The directed part of the bench keeps ticking through the synchronizer delay. This exposes the exact capture cycle and shows the one-cycle deferral of a coincident read.

// File: rtl/ts_pkg.sv
package ts_pkg;
   localparam int unsigned TS_CNT_W_DEF = 16;
   localparam int unsigned TS_SYNC_DEF  = 2;

   function automatic logic ts_is_top(input logic [63:0] v, input int unsigned w);
      logic all1;
      all1 = 1'b1;
      for (int i = 0; i < 64; i++)
         if (i < w) all1 &= v[i];
      return all1;
   endfunction
endpackage

// File: rtl/ts_tick_counter.sv
module ts_tick_counter #(
   parameter int unsigned CNT_W = ts_pkg::TS_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             lost_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic wrap;
   assign wrap = tick_i && (count_o == CNT_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o <= '0;
         irq_o   <= 1'b0;
         lost_o  <= 1'b0;
      end else begin
         if (tick_i) count_o <= count_o + 1'b1;
         if (wrap)       irq_o <= 1'b1;
         else if (ack_i) irq_o <= 1'b0;
         if (wrap && irq_o && !ack_i) lost_o <= 1'b1;
         else if (ack_i)              lost_o <= 1'b0;
      end
   end

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> count_o == $past(count_o) + 1'b1);
   p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(count_o));
   p_wrap_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> irq_o);
   p_irq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> irq_o);
   p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !wrap) |=> (!irq_o && !lost_o));
   p_lost_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && irq_o && !ack_i) |=> lost_o);
endmodule

// File: rtl/ts_pps_edge.sv
module ts_pps_edge #(
   parameter int unsigned STAGES     = ts_pkg::TS_SYNC_DEF,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pps_i,
   output logic edge_o
);
   logic             pps_in;
   logic [STAGES-1:0] sync_q;
   logic             prev_q;

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign pps_in = ~pps_i;
      end else begin : g_pass
         assign pps_in = pps_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pps_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign edge_o = sync_q[STAGES-1] && !prev_q;

   p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/ts_snap_reg.sv
module ts_snap_reg #(
   parameter int unsigned W = ts_pkg::TS_CNT_W_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] val_i,
   input  logic         take_i,
   output logic [W-1:0] value_o,
   output logic         valid_o,
   output logic         overrun_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_o   <= '0;
         valid_o   <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         if (cap_i) value_o <= val_i;
         if (cap_i)       valid_o <= 1'b1;
         else if (take_i) valid_o <= 1'b0;
         if (take_i)                overrun_o <= 1'b0;
         else if (cap_i && valid_o) overrun_o <= 1'b1;
      end
   end

   p_cap_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (valid_o && value_o == $past(val_i)));
   p_take_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !cap_i) |=> (!valid_o && !overrun_o));
   p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && valid_o && !take_i) |=> overrun_o);
endmodule

// File: rtl/ts_latch_core.sv
module ts_latch_core #(
   parameter int unsigned CNT_W       = ts_pkg::TS_CNT_W_DEF,
   parameter int unsigned SYNC_STAGES = ts_pkg::TS_SYNC_DEF,
   parameter bit          PPS_LOW     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ack_i,
   input  logic             rd_strobe_i,
   input  logic             rd_take_i,
   input  logic             pps_i,
   input  logic             pps_take_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_irq_o,
   output logic             ovf_lost_o,
   output logic [CNT_W-1:0] rd_value_o,
   output logic             rd_valid_o,
   output logic             rd_overrun_o,
   output logic [CNT_W-1:0] pps_value_o,
   output logic             pps_valid_o,
   output logic             pps_overrun_o
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("ts_latch_core: CNT_W must lie in 2..64");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ts_latch_core: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic pps_edge;
   logic rd_pend_q;
   logic rd_fire;

   ts_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
      .count_o(count_o), .irq_o(ovf_irq_o), .lost_o(ovf_lost_o));

   ts_pps_edge #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(PPS_LOW)) u_edge (
      .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .edge_o(pps_edge));

   // Pulse capture has priority; a clashing read is deferred by one cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) rd_pend_q <= 1'b0;
      else        rd_pend_q <= rd_strobe_i && pps_edge;
   end

   assign rd_fire = (rd_strobe_i && !pps_edge) || rd_pend_q;

   ts_snap_reg #(.W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .cap_i(rd_fire), .val_i(count_o),
      .take_i(rd_take_i), .value_o(rd_value_o), .valid_o(rd_valid_o),
      .overrun_o(rd_overrun_o));

   ts_snap_reg #(.W(CNT_W)) u_pps (
      .clk(clk), .rst_n(rst_n), .cap_i(pps_edge), .val_i(count_o),
      .take_i(pps_take_i), .value_o(pps_value_o), .valid_o(pps_valid_o),
      .overrun_o(pps_overrun_o));

   p_pps_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pps_edge && rd_strobe_i) |=> (pps_valid_o && rd_fire));
   p_no_dual_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pps_edge && rd_strobe_i && !rd_take_i) |=> (rd_valid_o == $past(rd_valid_o)));
endmodule

// File: tb/ts_latch_core_bench.sv
module ts_latch_core_bench;
   localparam int unsigned W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, ack = 1'b0, rd = 1'b0, rd_take = 1'b0, pps = 1'b0, pps_take = 1'b0;
   logic [W-1:0] count, rd_value, pps_value;
   logic ovf_irq, ovf_lost, rd_valid, rd_overrun, pps_valid, pps_overrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ts_latch_core #(.CNT_W(W), .SYNC_STAGES(2), .PPS_LOW(1'b0)) u_ts_latch_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ack_i(ack),
      .rd_strobe_i(rd), .rd_take_i(rd_take), .pps_i(pps), .pps_take_i(pps_take),
      .count_o(count), .ovf_irq_o(ovf_irq), .ovf_lost_o(ovf_lost),
      .rd_value_o(rd_value), .rd_valid_o(rd_valid), .rd_overrun_o(rd_overrun),
      .pps_value_o(pps_value), .pps_valid_o(pps_valid), .pps_overrun_o(pps_overrun));

   // ticks to apply [11:4], expected counter afterwards [3:0]
   localparam logic [11:0] VEC [6] = '{
      {8'd3, 4'd3}, {8'd5, 4'd8}, {8'd7, 4'd15},
      {8'd1, 4'd0}, {8'd2, 4'd2}, {8'd14, 4'd0}};

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int c0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R10 reset state
      chk("R10 count", count, 0);
      chk("R10 irq", ovf_irq, 0);
      chk("R10 lost", ovf_lost, 0);
      chk("R10 rd_valid", rd_valid, 0);
      chk("R10 pps_valid", pps_valid, 0);
      chk("R10 pps_value", pps_value, 0);

      // vector table: ticks then read snapshot (R1, R5)
      for (int i = 0; i < 6; i++) begin
         tick = 1'b1;
         repeat (VEC[i][11:4]) cyc();
         tick = 1'b0;
         chk("R1 count", count, VEC[i][3:0]);
         rd = 1'b1; cyc(); rd = 1'b0;
         chk("R5 rd_value", rd_value, VEC[i][3:0]);
         chk("R5 rd_valid", rd_valid, 1);
         rd_take = 1'b1; cyc(); rd_take = 1'b0;
         chk("R8 rd_valid cleared", rd_valid, 0);
      end
      // two rollovers, second while pending
      chk("R2 irq after wrap", ovf_irq, 1);
      chk("R4 lost", ovf_lost, 1);
      repeat (3) cyc();
      chk("R2 irq held", ovf_irq, 1);
      ack = 1'b1; cyc(); ack = 1'b0;
      chk("R3 irq cleared", ovf_irq, 0);
      chk("R3 lost cleared", ovf_lost, 0);

      // R2 ack coincident with rollover, irq already set
      tick = 1'b1; repeat (16) cyc();
      chk("R2 irq set", ovf_irq, 1);
      repeat (15) cyc();
      chk("R1 at top", count, 15);
      ack = 1'b1; cyc(); ack = 1'b0; tick = 1'b0;
      chk("R2 wrap beats ack", ovf_irq, 1);
      chk("R4 no lost with ack", ovf_lost, 0);
      chk("R1 rolled", count, 0);
      ack = 1'b1; cyc(); ack = 1'b0;
      chk("R3 cleared again", ovf_irq, 0);

      // R6 pulse capture timing while ticking
      tick = 1'b1;
      c0 = count;
      pps = 1'b1;
      cyc(); cyc();
      chk("R6 not yet", pps_valid, 0);
      cyc();
      chk("R6 pps_valid", pps_valid, 1);
      chk("R6 pps_value", pps_value, (c0 + 2) % 16);
      tick = 1'b0;
      pps_take = 1'b1; cyc(); pps_take = 1'b0;
      chk("R8 pps cleared", pps_valid, 0);
      repeat (4) cyc();
      chk("R6 level no recapture", pps_valid, 0);
      pps = 1'b0; repeat (3) cyc();

      // R7 coincident pulse edge and read strobe
      tick = 1'b1;
      c0 = count;
      pps = 1'b1;
      cyc(); cyc();
      rd = 1'b1; cyc(); rd = 1'b0;
      chk("R7 pps first", pps_valid, 1);
      chk("R7 pps_value", pps_value, (c0 + 2) % 16);
      chk("R7 read deferred", rd_valid, 0);
      cyc();
      tick = 1'b0;
      chk("R7 read served", rd_valid, 1);
      chk("R7 read value", rd_value, (c0 + 3) % 16);

      // R9 second pulse without take
      pps = 1'b0; repeat (3) cyc();
      tick = 1'b1; cyc(); tick = 1'b0;
      c0 = count;
      pps = 1'b1; repeat (3) cyc();
      chk("R9 overrun", pps_overrun, 1);
      chk("R9 newest value", pps_value, c0);
      chk("R8 still valid", pps_valid, 1);
      pps_take = 1'b1; rd_take = 1'b1; cyc(); pps_take = 1'b0; rd_take = 1'b0;
      chk("R8 overrun cleared", pps_overrun, 0);
      chk("R8 valid cleared", pps_valid, 0);
      chk("R8 rd cleared", rd_valid, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule